// File: doc/BRIEF.md
# Indexed Receive Message FIFO

This block keeps a ring of fixed-size receive elements in a local word memory and tracks its occupancy for a host. Each element is four 32-bit words. A frame arrives on a 128-bit write port together with a one-cycle valid strobe and is stored at the put index. The host looks at the element at the get index through decoded head outputs. It then releases that element, and optionally every older one, by writing an index to the acknowledge register.

A configuration register sets the ring's element count, a watermark level and the word-aligned byte address where the ring starts in memory. A status word reports the fill level, both indices, a full flag and a sticky message-lost flag. When the ring is full it blocks: an arriving frame is thrown away and counted as lost. Four one-cycle event outputs report a stored frame, a watermark hit, the ring becoming full and a lost frame.

Top module: `rx_msg_fifo`

## Requirements
- R1: After reset the configuration readback, the status word and all four event outputs are zero, and `headValid` is low.
- R2: A write with `regSel`=0 loads the configuration. The start byte address goes in bits 15:2, the element count in bits 22:16 and the watermark in bits 30:24. Readback returns these fields and zero elsewhere. The same write empties the ring, clears both indices and clears the lost flag, and a frame offered in that cycle is dropped silently. A count above 64 acts as 64.
- R3: A frame offered while the ring is enabled and not full is stored at the put index. In the next cycle the put index has advanced, the fill level is one higher and `evNewMsg` is high for one cycle. Status bits 6:0 hold the fill level, bits 13:8 the get index and bits 21:16 the put index.
- R4: The head outputs decode the element at the get index. Word 0 bit 30 is the extended flag and bit 29 the remote flag. An extended identifier is word 0 bits 28:0, and a standard identifier is word 0 bits 28:18, right-aligned. The length code is word 1 bits 19:16. `headData` is word 3 over word 2.
- R5: Writing the current get index to the acknowledge register (`regSel`=1, index in bits 5:0) releases that element: the get index advances and the fill level drops by one.
- R6: An acknowledged index that lies inside the occupied span releases every element from the get index up to and including it. The get index then becomes that index plus one. An index outside the span, or not below the count, is ignored.
- R7: Both indices wrap to 0 after reaching count minus one.
- R8: Status bit 24 is high exactly when the fill level equals a nonzero count. `evFull` pulses in the cycle after a store that makes the ring full.
- R9: A frame offered while the ring is full is discarded. The stored contents and fill level are unchanged, status bit 25 becomes set and stays set until the next configuration write, and `evLost` pulses.
- R10: `evWmark` pulses in the cycle after a store that raises the fill level to the nonzero watermark. A watermark of 0 never produces it.
- R11: With a count of 0 every frame is dropped without storing, without setting the lost flag and without any event.
- R12: A frame and an acknowledge in the same cycle both take effect. Whether the frame is accepted depends on the fill level before the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frmValid | input | 1 | Incoming frame strobe |
| frmWords | input | 128 | Frame words, word 0 in bits 31:0 |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects configuration, 1 selects acknowledge |
| regWrData | input | 32 | Register write data |
| cfgRd | output | 32 | Configuration readback |
| statusRd | output | 32 | Status word |
| headValid | output | 1 | Ring holds at least one element |
| headId | output | 29 | Decoded identifier of the head element |
| headExt | output | 1 | Head extended flag |
| headRtr | output | 1 | Head remote flag |
| headEsi | output | 1 | Head word 0 bit 31 |
| headLen | output | 4 | Head length code |
| headW1 | output | 32 | Head word 1 raw |
| headData | output | 64 | Head data, word 3 over word 2 |
| evNewMsg | output | 1 | Frame stored |
| evWmark | output | 1 | Watermark reached |
| evFull | output | 1 | Ring became full |
| evLost | output | 1 | Frame lost while full |

## Verification
A store and a release can land in the same clock cycle, and the block must then decide acceptance using the fill level from before the release. The bench offers a frame together with an acknowledge in two situations. In the first the ring is full, so the frame must be dropped with `evLost` while the acknowledge still frees elements. In the second the ring is part full, so the fill level must come out unchanged while the put index advances and the head moves on. In each case it judges the fill level, both indices, the head identifier and the events one cycle later.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;
  localparam int MAX_ELEMS = 64;
  localparam int IDX_W = $clog2(MAX_ELEMS);
  localparam int LVL_W = $clog2(MAX_ELEMS + 1);
  localparam int WORDS_PER_ELEM = 4;

  typedef struct packed {
    logic             storeEn;
    logic [IDX_W-1:0] putIdx;
    logic [IDX_W-1:0] getIdx;
  } dpStrobe_t;
endpackage

// File: rtl/rxfifo_ctrl.sv
module rxfifo_ctrl
  import rxfifo_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frmValid,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [31:0]       regWrData,
  output logic [31:0]       cfgRd,
  output logic [31:0]       statusRd,
  output logic [ADDR_W-1:0] startWord,
  output dpStrobe_t         strb,
  output logic              headValid,
  output logic              evNewMsg,
  output logic              evWmark,
  output logic              evFull,
  output logic              evLost
);
  localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(MAX_ELEMS);

  logic [13:0]      cfgStartQ;
  logic [6:0]       cfgSizeQ;
  logic [6:0]       cfgWmQ;
  logic [IDX_W-1:0] putQ, getQ, putNext, getNext;
  logic [LVL_W-1:0] fillQ, fillNext, effSize, ackOff, relCnt, ackIdxL, getL;
  logic             lostQ;
  logic             cfgWr, ackWr, ackOk, isFull, store, drop;

  function automatic logic [IDX_W-1:0] stepIdx(logic [IDX_W-1:0] v, logic [LVL_W-1:0] sz);
    logic [LVL_W-1:0] n;
    n = {1'b0, v} + LVL_W'(1);
    return (n >= sz) ? '0 : n[IDX_W-1:0];
  endfunction

  assign effSize = (LVL_W'(cfgSizeQ) > MAX_LVL) ? MAX_LVL : LVL_W'(cfgSizeQ);
  assign isFull  = (effSize != '0) && (fillQ == effSize);
  assign cfgWr   = regWrEn && !regSel;
  assign ackWr   = regWrEn && regSel;

  assign ackIdxL = {1'b0, regWrData[IDX_W-1:0]};
  assign getL    = {1'b0, getQ};
  assign ackOff  = (ackIdxL >= getL) ? (ackIdxL - getL) : (ackIdxL + effSize - getL);
  assign ackOk   = ackWr && (ackIdxL < effSize) && (ackOff < fillQ);
  assign relCnt  = ackOk ? ackOff + LVL_W'(1) : '0;

  assign store = frmValid && !cfgWr && (effSize != '0) && !isFull;
  assign drop  = frmValid && !cfgWr && (effSize != '0) && isFull;

  assign fillNext = fillQ + LVL_W'(store) - relCnt;
  assign putNext  = store ? stepIdx(putQ, effSize) : putQ;
  assign getNext  = ackOk ? stepIdx(regWrData[IDX_W-1:0], effSize) : getQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgStartQ <= '0;
      cfgSizeQ  <= '0;
      cfgWmQ    <= '0;
      putQ      <= '0;
      getQ      <= '0;
      fillQ     <= '0;
      lostQ     <= 1'b0;
      evNewMsg  <= 1'b0;
      evWmark   <= 1'b0;
      evFull    <= 1'b0;
      evLost    <= 1'b0;
    end else if (cfgWr) begin
      cfgStartQ <= regWrData[15:2];
      cfgSizeQ  <= regWrData[22:16];
      cfgWmQ    <= regWrData[30:24];
      putQ      <= '0;
      getQ      <= '0;
      fillQ     <= '0;
      lostQ     <= 1'b0;
      evNewMsg  <= 1'b0;
      evWmark   <= 1'b0;
      evFull    <= 1'b0;
      evLost    <= 1'b0;
    end else begin
      putQ     <= putNext;
      getQ     <= getNext;
      fillQ    <= fillNext;
      lostQ    <= lostQ | drop;
      evNewMsg <= store;
      evWmark  <= store && (cfgWmQ != '0) && (fillNext == LVL_W'(cfgWmQ)) && (fillNext != fillQ);
      evFull   <= store && (fillNext == effSize);
      evLost   <= drop;
    end
  end

  assign cfgRd     = {1'b0, cfgWmQ, 1'b0, cfgSizeQ, cfgStartQ, 2'b00};
  assign statusRd  = {6'b0, lostQ, isFull, 2'b0, putQ, 2'b0, getQ, 1'b0, fillQ};
  assign startWord = cfgStartQ[ADDR_W-1:0];
  assign headValid = (fillQ != '0);

  assign strb.storeEn = store;
  assign strb.putIdx  = putQ;
  assign strb.getIdx  = getQ;
endmodule

// File: rtl/rxfifo_dpath.sv
module rxfifo_dpath
  import rxfifo_pkg::*;
#(
  parameter int RAM_WORDS = 512,
  localparam int ADDR_W = $clog2(RAM_WORDS)
) (
  input  logic              clk,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] startWord,
  input  logic [127:0]      frmWords,
  output logic [28:0]       headId,
  output logic              headExt,
  output logic              headRtr,
  output logic              headEsi,
  output logic [3:0]        headLen,
  output logic [31:0]       headW1,
  output logic [63:0]       headData
);
  logic [31:0]       mem [RAM_WORDS];
  logic [ADDR_W-1:0] wrBase, rdBase;
  logic [31:0]       rdWord [WORDS_PER_ELEM];

  assign wrBase = startWord + ADDR_W'({strb.putIdx, 2'b00});
  assign rdBase = startWord + ADDR_W'({strb.getIdx, 2'b00});

  always_ff @(posedge clk) begin
    if (strb.storeEn) begin
      for (int w = 0; w < WORDS_PER_ELEM; w++) begin
        mem[wrBase + ADDR_W'(w)] <= frmWords[w*32 +: 32];
      end
    end
  end

  for (genvar g = 0; g < WORDS_PER_ELEM; g++) begin : g_rd
    assign rdWord[g] = mem[rdBase + ADDR_W'(g)];
  end

  assign headEsi  = rdWord[0][31];
  assign headExt  = rdWord[0][30];
  assign headRtr  = rdWord[0][29];
  assign headId   = rdWord[0][30] ? rdWord[0][28:0] : {18'b0, rdWord[0][28:18]};
  assign headW1   = rdWord[1];
  assign headLen  = rdWord[1][19:16];
  assign headData = {rdWord[3], rdWord[2]};
endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo
  import rxfifo_pkg::*;
#(
  parameter int RAM_WORDS = 512
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         frmValid,
  input  logic [127:0] frmWords,
  input  logic         regWrEn,
  input  logic         regSel,
  input  logic [31:0]  regWrData,
  output logic [31:0]  cfgRd,
  output logic [31:0]  statusRd,
  output logic         headValid,
  output logic [28:0]  headId,
  output logic         headExt,
  output logic         headRtr,
  output logic         headEsi,
  output logic [3:0]   headLen,
  output logic [31:0]  headW1,
  output logic [63:0]  headData,
  output logic         evNewMsg,
  output logic         evWmark,
  output logic         evFull,
  output logic         evLost
);
  localparam int ADDR_W = $clog2(RAM_WORDS);

  dpStrobe_t         strb;
  logic [ADDR_W-1:0] startWord;

  rxfifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .cfgRd(cfgRd), .statusRd(statusRd),
    .startWord(startWord), .strb(strb), .headValid(headValid),
    .evNewMsg(evNewMsg), .evWmark(evWmark), .evFull(evFull), .evLost(evLost)
  );

  rxfifo_dpath #(.RAM_WORDS(RAM_WORDS)) u_dpath (
    .clk(clk), .strb(strb), .startWord(startWord), .frmWords(frmWords),
    .headId(headId), .headExt(headExt), .headRtr(headRtr), .headEsi(headEsi),
    .headLen(headLen), .headW1(headW1), .headData(headData)
  );
endmodule

// File: rtl/rx_msg_fifo_chk.sv
module rx_msg_fifo_chk (
  input logic        clk,
  input logic        rstN,
  input logic        frmValid,
  input logic        regWrEn,
  input logic        regSel,
  input logic [31:0] regWrData,
  input logic [31:0] cfgRd,
  input logic [31:0] statusRd,
  input logic        evNewMsg,
  input logic        evLost
);
  logic [6:0] effSize;
  logic       cfgWr;
  assign effSize = (cfgRd[22:16] > 7'd64) ? 7'd64 : cfgRd[22:16];
  assign cfgWr   = regWrEn && !regSel;

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    statusRd[6:0] <= effSize); // R8

  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (statusRd == 32'd0)); // R2

  AST_NEW_ON_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !cfgWr && effSize != 7'd0 && !statusRd[24]) |=> evNewMsg); // R3

  AST_ACK_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel && !frmValid && statusRd[6:0] != 7'd0 && regWrData[5:0] == statusRd[13:8])
      |=> (statusRd[6:0] == 7'($past(statusRd[6:0]) - 7'd1))); // R5

  AST_LOST_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !cfgWr && statusRd[24]) |=> (statusRd[25] && evLost)); // R9

  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd[25] && !cfgWr) |=> statusRd[25]); // R9

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRd[22:16] == 7'd0) |=> (!evNewMsg && !evLost)); // R11

  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(evNewMsg && evLost)); // R12
endmodule

bind rx_msg_fifo rx_msg_fifo_chk u_chk (
  .clk(clk), .rstN(rstN), .frmValid(frmValid), .regWrEn(regWrEn),
  .regSel(regSel), .regWrData(regWrData), .cfgRd(cfgRd), .statusRd(statusRd),
  .evNewMsg(evNewMsg), .evLost(evLost)
);

// File: tb/rx_msg_fifo_tb.sv
module rx_msg_fifo_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         frmValid = 1'b0;
  logic [127:0] frmWords = '0;
  logic         regWrEn = 1'b0;
  logic         regSel = 1'b0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  cfgRd, statusRd, headW1;
  logic         headValid, headExt, headRtr, headEsi;
  logic [28:0]  headId;
  logic [3:0]   headLen;
  logic [63:0]  headData;
  logic         evNewMsg, evWmark, evFull, evLost;

  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  rx_msg_fifo u_dut (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmWords(frmWords),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .cfgRd(cfgRd), .statusRd(statusRd), .headValid(headValid), .headId(headId),
    .headExt(headExt), .headRtr(headRtr), .headEsi(headEsi), .headLen(headLen),
    .headW1(headW1), .headData(headData), .evNewMsg(evNewMsg), .evWmark(evWmark),
    .evFull(evFull), .evLost(evLost)
  );

  typedef struct packed {
    logic [31:0] w0, w1, w2, w3;
    logic [28:0] id;
    logic        ext, rtr;
    logic [3:0]  len;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{32'h048C_0000, 32'h0008_0000, 32'h1122_3344, 32'h5566_7788, 29'h123,       1'b0, 1'b0, 4'h8},
    '{32'h5ABC_DEF0, 32'h000F_0000, 32'hA1A2_A3A4, 32'hB1B2_B3B4, 29'h1ABC_DEF0, 1'b1, 1'b0, 4'hF},
    '{32'h3FFC_0000, 32'hFFF0_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 29'h7FF,       1'b0, 1'b1, 4'h0},
    '{32'h6000_0001, 32'h0003_0000, 32'hC0DE_0001, 32'hC0DE_0002, 29'h1,         1'b1, 1'b1, 4'h3}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] stdFrm(input logic [10:0] id);
    return {32'h0, 32'h0, 32'h0008_0000, {3'b000, id, 18'h0}};
  endfunction

  task automatic cfgWrite(input logic [6:0] size, input logic [6:0] wm, input logic [15:0] start);
    regWrEn = 1'b1; regSel = 1'b0;
    regWrData = {1'b0, wm, 1'b0, size, start};
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic push(input logic [127:0] f);
    frmValid = 1'b1; frmWords = f;
    @(negedge clk);
    frmValid = 1'b0;
  endtask

  task automatic ack(input logic [5:0] idx);
    regWrEn = 1'b1; regSel = 1'b1; regWrData = {26'h0, idx};
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pushAck(input logic [127:0] f, input logic [5:0] idx);
    frmValid = 1'b1; frmWords = f;
    regWrEn = 1'b1; regSel = 1'b1; regWrData = {26'h0, idx};
    @(negedge clk);
    frmValid = 1'b0; regWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg", cfgRd, 0);
    chk("R1 status", statusRd, 0);
    chk("R1 events", {evNewMsg, evWmark, evFull, evLost, headValid}, 0);

    // R2 configuration fields
    cfgWrite(7'd4, 7'd3, 16'h0040);
    chk("R2 cfg readback", cfgRd, 32'h0304_0040);

    // R3 R4 R5 R7: table of frames, each stored, decoded, released
    for (int i = 0; i < 4; i++) begin
      push({VECS[i].w3, VECS[i].w2, VECS[i].w1, VECS[i].w0});
      chk("R3 evNewMsg", evNewMsg, 1);
      chk("R3 fill", statusRd[6:0], 1);
      chk("R3 put", statusRd[21:16], (i + 1) % 4);
      chk("R4 id", headId, VECS[i].id);
      chk("R4 ext/rtr", {headExt, headRtr}, {VECS[i].ext, VECS[i].rtr});
      chk("R4 len", headLen, VECS[i].len);
      chk("R4 data", headData, {VECS[i].w3, VECS[i].w2});
      ack(6'(i));
      chk("R5 fill after ack", statusRd[6:0], 0);
      chk("R5 get after ack", statusRd[13:8], (i + 1) % 4);
    end
    chk("R7 wrapped indices", {statusRd[21:16], statusRd[13:8]}, 0);

    // R8 R10: fill to watermark and to full
    push(stdFrm(11'h10));
    push(stdFrm(11'h11));
    chk("R10 no wmark at 2", evWmark, 0);
    push(stdFrm(11'h12));
    chk("R10 wmark at 3", evWmark, 1);
    chk("R8 not full at 3", {evFull, statusRd[24]}, 0);
    push(stdFrm(11'h13));
    chk("R8 evFull", evFull, 1);
    chk("R8 full bit", statusRd[24], 1);
    chk("R8 fill", statusRd[6:0], 4);

    // R9 blocking loss
    push(stdFrm(11'h7FF));
    chk("R9 evLost/new", {evLost, evNewMsg}, 2'b10);
    chk("R9 lost bit", statusRd[25], 1);
    chk("R9 fill kept", statusRd[6:0], 4);
    chk("R9 head kept", headId, 29'h10);

    // R6 multi release and ignored indices
    ack(6'd2);
    chk("R6 fill multi", statusRd[6:0], 1);
    chk("R6 get multi", statusRd[13:8], 3);
    chk("R6 head", headId, 29'h13);
    ack(6'd1);
    chk("R6 outside span ignored", statusRd[13:0], {6'd3, 1'b0, 7'd1});
    ack(6'd5);
    chk("R6 beyond size ignored", statusRd[13:0], {6'd3, 1'b0, 7'd1});
    chk("R9 lost sticky", statusRd[25], 1);

    // R12 frame and acknowledge together
    push(stdFrm(11'h20));
    push(stdFrm(11'h21));
    push(stdFrm(11'h22));
    chk("R12 setup full", statusRd[24], 1);
    pushAck(stdFrm(11'h30), 6'd3);
    chk("R12 full: frame dropped", {evLost, evNewMsg}, 2'b10);
    chk("R12 full: fill", statusRd[6:0], 3);
    chk("R12 full: head", headId, 29'h20);
    pushAck(stdFrm(11'h31), 6'd0);
    chk("R12 partial: stored", evNewMsg, 1);
    chk("R12 partial: fill", statusRd[6:0], 3);
    chk("R12 partial: indices", {statusRd[21:16], statusRd[13:8]}, {6'd0, 6'd1});
    chk("R12 partial: head", headId, 29'h21);
    ack(6'd3);
    chk("R7 wrap release", {statusRd[13:8], statusRd[6:0]}, 0);
    chk("R7 head invalid", headValid, 0);

    // R2 config write clears, R10 watermark zero
    push(stdFrm(11'h40));
    cfgWrite(7'd4, 7'd0, 16'h0);
    chk("R2 cleared status", statusRd, 0);
    push(stdFrm(11'h41));
    chk("R10 wm zero", evWmark, 0);
    chk("R3 stored after cfg", statusRd[6:0], 1);

    // R11 disabled
    cfgWrite(7'd0, 7'd0, 16'h0);
    push(stdFrm(11'h50));
    chk("R11 no events", {evNewMsg, evLost, evWmark, evFull}, 0);
    chk("R11 status", statusRd, 0);

    // R2 clamp above 64
    cfgWrite(7'd100, 7'd0, 16'h0100);
    chk("R2 raw size readback", cfgRd[22:16], 100);
    for (int k = 0; k < 64; k++) push(stdFrm(11'(k)));
    chk("R2 clamp fill", statusRd[6:0], 64);
    chk("R2 clamp full", statusRd[24], 1);
    chk("R2 clamp put wrap", statusRd[21:16], 0);
    push(stdFrm(11'h7AA));
    chk("R9 lost at clamp", evLost, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule